// File: doc/BRIEF.md
# USB Dual-Role Mode Controller

This block decides the top-level operating state of a USB controller that can act as either a peripheral or a host. It holds three states: Reset, Device and Host. Software drives it through a small register port. One register holds the enable bit, the clock-freeze bit and the pad settings. A second register holds the low-speed force bit. A third, read-only register reports the synchronized ID and VBUS pin levels and the current mode.

Out of Reset the block enters Device or Host mode, using either the ID pin or a software mode-select bit. It drives the clock-enable for the protocol engines, the suspend request to the transceiver and one synchronous reset each for the device-side and host-side logic. It also drives the pad and speed values that are in force. Software may write new pad and speed settings at any time. Those settings reach the outputs only while the block is enabled and its clock is not frozen.

Top module: `usb_role_ctrl`

## Requirements
- R1: After `rst_n` is asserted:
  - `mode` is 0 (Reset).
  - `clk_en` is 0.
  - Register 0 reads 0x32, which means enable=0, freeze=1, ID-pin select=1 and mode-select=1.
  - Register 1 reads 0.
  - The applied outputs are `pad_en`=0, `vbus_pol`=0, `id_sel`=1, `mode_sel`=1 and `ls_force`=0.
- R2: Whenever the enable bit (register 0 bit 0) is 0 at a clock edge, `mode` is 0 (Reset) after that edge, whatever the previous mode.
- R3: In Reset with enable=1, the next edge picks a target. When register 0 bit 4 (ID-pin select) is 1, the target is the synchronized ID level. Otherwise it is register 0 bit 5 (mode-select). A target of 1 enters Device (`mode`=1) and a target of 0 enters Host (`mode`=2).
- R4: If the target no longer matches the current mode while enabled, the block spends one cycle in Reset before it enters the other mode. Device never changes to Host, and Host never changes to Device, in a single cycle.
- R5: The control outputs depend on the mode:
  - In Reset, `xcvr_suspend`, `dev_rst` and `host_rst` are all 1.
  - In Device, only `host_rst` is 1.
  - In Host, only `dev_rst` is 1.
- R6: Register 2 (read-only) reports bit 0 = synchronized ID, bit 1 = synchronized VBUS and bits 3:2 = `mode`. A pin change appears there two clock edges later in every state, including Reset and while frozen.
- R7: The configuration bits can be written in any state and read back at once. These bits are register 0 bits 2 (pad enable), 3 (VBUS polarity), 4 and 5, and register 1 bit 0 (low-speed force). The applied outputs copy them only at an edge where enable=1 and freeze=0. Otherwise the applied outputs hold.
- R8: `clk_en` is 1 exactly when enable=1 and freeze (register 0 bit 1)=0.
- R9: Address 3 reads 0, and writes to addresses 2 and 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_pin | input | 1 | Raw ID pin level (1 = not grounded) |
| vbus_pin | input | 1 | Raw VBUS level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 6 | Read data for `reg_addr` (combinational) |
| mode | output | 2 | 0 Reset, 1 Device, 2 Host |
| clk_en | output | 1 | Clock enable for the protocol engines |
| xcvr_suspend | output | 1 | Suspend request to the transceiver |
| dev_rst | output | 1 | Synchronous reset of the device-side logic |
| host_rst | output | 1 | Synchronous reset of the host-side logic |
| pad_en | output | 1 | Applied pad enable |
| vbus_pol | output | 1 | Applied VBUS polarity |
| id_sel | output | 1 | Applied ID-pin select |
| mode_sel | output | 1 | Applied mode-select |
| ls_force | output | 1 | Applied low-speed force |

## Verification
The assertions check these rules on every cycle:
- the return to Reset when enable drops;
- the choice of mode out of Reset;
- the ban on a direct Device-to-Host or Host-to-Device change;
- the output pattern for each mode;
- the hold of the applied configuration while disabled or frozen;
- the clock-enable condition.

Only the bench's scenarios can show the following:
- the reset values;
- the register readback and the ignored addresses;
- the two-cycle delay of the pin synchronizer into the status register;
- that status keeps tracking the pins while in Reset and frozen.

The bench shows these by comparing every output each cycle against a model driven by directed and random register traffic.

// File: rtl/usb_role_ctrl.sv
module usb_role_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_pin,
  input  logic              vbus_pin,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [1:0]        mode,
  output logic              clk_en,
  output logic              xcvr_suspend,
  output logic              dev_rst,
  output logic              host_rst,
  output logic              pad_en,
  output logic              vbus_pol,
  output logic              id_sel,
  output logic              mode_sel,
  output logic              ls_force
);

  localparam logic [1:0] ST_RESET = 2'd0;
  localparam logic [1:0] ST_DEV   = 2'd1;
  localparam logic [1:0] ST_HOST  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SPD  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);

  logic [SYNC_STAGES-1:0] id_sync, vbus_sync;
  logic id_s, vbus_s;
  logic en_q, frz_q, pade_q, vpol_q, uide_q, msel_q, ls_q;
  logic [1:0] st_q;
  logic want_dev, apply;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      id_sync   <= '1;
      vbus_sync <= '0;
    end else begin
      id_sync   <= {id_sync[SYNC_STAGES-2:0], id_pin};
      vbus_sync <= {vbus_sync[SYNC_STAGES-2:0], vbus_pin};
    end

  assign id_s   = id_sync[SYNC_STAGES-1];
  assign vbus_s = vbus_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {msel_q, uide_q, vpol_q, pade_q, frz_q, en_q} <= 6'b110010;
      ls_q <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL)
        {msel_q, uide_q, vpol_q, pade_q, frz_q, en_q} <= reg_wdata[5:0];
      else if (reg_addr == A_SPD)
        ls_q <= reg_wdata[0];
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[5:0] = {msel_q, uide_q, vpol_q, pade_q, frz_q, en_q};
      A_SPD:   reg_rdata[0]   = ls_q;
      A_STAT:  reg_rdata[3:0] = {st_q, vbus_s, id_s};
      default: reg_rdata = '0;
    endcase
  end

  assign want_dev = uide_q ? id_s : msel_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= ST_RESET;
    else begin
      case (st_q)
        ST_RESET: if (en_q) st_q <= want_dev ? ST_DEV : ST_HOST;
        ST_DEV:   if (!en_q || !want_dev) st_q <= ST_RESET;
        ST_HOST:  if (!en_q || want_dev) st_q <= ST_RESET;
        default:  st_q <= ST_RESET;
      endcase
    end

  assign apply = en_q & ~frz_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {mode_sel, id_sel, vbus_pol, pad_en, ls_force} <= 5'b11000;
    end else if (apply) begin
      {mode_sel, id_sel, vbus_pol, pad_en, ls_force} <= {msel_q, uide_q, vpol_q, pade_q, ls_q};
    end

  assign mode         = st_q;
  assign clk_en       = apply;
  assign xcvr_suspend = (st_q == ST_RESET);
  assign dev_rst      = (st_q != ST_DEV);
  assign host_rst     = (st_q != ST_HOST);

endmodule

// File: rtl/usb_role_ctrl_chk.sv
module usb_role_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       frz,
  input logic       uide,
  input logic       msel,
  input logic       id_s,
  input logic [1:0] mode,
  input logic       clk_en,
  input logic       xcvr_suspend,
  input logic       dev_rst,
  input logic       host_rst,
  input logic [4:0] applied
);

  logic tgt;
  assign tgt = uide ? id_s : msel;

  assert_disable_to_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> mode == 2'd0);

  assert_enter_device_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && en && tgt) |=> mode == 2'd1);

  assert_enter_host_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && en && !tgt) |=> mode == 2'd2);

  assert_no_dev_to_host_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd1 |=> mode != 2'd2);

  assert_no_host_to_dev_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 |=> mode != 2'd1);

  assert_reset_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd0 |-> (xcvr_suspend && dev_rst && host_rst));

  assert_active_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd0 |-> (!xcvr_suspend && $countones({dev_rst, host_rst}) == 1));

  assert_hold_applied_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && !frz) |=> $stable(applied));

  assert_clk_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> (en && !frz));

endmodule

bind usb_role_ctrl usb_role_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .frz(frz_q), .uide(uide_q), .msel(msel_q),
  .id_s(id_s), .mode(mode), .clk_en(clk_en), .xcvr_suspend(xcvr_suspend),
  .dev_rst(dev_rst), .host_rst(host_rst),
  .applied({mode_sel, id_sel, vbus_pol, pad_en, ls_force})
);

// File: tb/test_usb_role_ctrl.sv
`timescale 1ns/1ps
module test_usb_role_ctrl;
  logic clk = 0, rst_n = 0;
  logic id_pin = 1, vbus_pin = 0, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [5:0] reg_wdata = 0;
  logic [5:0] reg_rdata;
  logic [1:0] mode;
  logic clk_en, xcvr_suspend, dev_rst, host_rst, pad_en, vbus_pol, id_sel, mode_sel, ls_force;

  usb_role_ctrl i_usb_role_ctrl (.*);

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [1:0] m_st;
  logic [5:0] m_ctrl;
  logic m_ls;
  logic [4:0] m_app;
  logic id1, id2, vb1, vb2;

  function automatic logic [5:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return {5'd0, m_ls};
      2'd2: return {2'd0, m_st, vb2, id2};
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [1:0] exp_next_mode(logic [1:0] st, logic [5:0] c, logic ids);
    logic tgt;
    tgt = c[4] ? ids : c[5];
    if (!c[0]) return 2'd0;
    case (st)
      2'd0: return tgt ? 2'd1 : 2'd2;
      2'd1: return tgt ? 2'd1 : 2'd0;
      2'd2: return tgt ? 2'd0 : 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_ctrl = 6'h32; m_ls = 0; m_app = 5'b11000;
    id1 = 1; id2 = 1; vb1 = 0; vb2 = 0;
  endtask

  task automatic compare_all();
    chk(mode == m_st, "R2/R3/R4 mode", mode, m_st);
    chk({xcvr_suspend, dev_rst, host_rst} ==
        {m_st == 2'd0, m_st != 2'd1, m_st != 2'd2}, "R5 control outputs",
        {xcvr_suspend, dev_rst, host_rst}, {m_st == 2'd0, m_st != 2'd1, m_st != 2'd2});
    chk(clk_en == (m_ctrl[0] & ~m_ctrl[1]), "R8 clk_en", clk_en, m_ctrl[0] & ~m_ctrl[1]);
    chk({mode_sel, id_sel, vbus_pol, pad_en, ls_force} == m_app, "R7 applied config",
        {mode_sel, id_sel, vbus_pol, pad_en, ls_force}, m_app);
    chk(reg_rdata == exp_read(reg_addr),
        reg_addr == 2 ? "R6 status" : (reg_addr == 3 ? "R9 unused addr" : "R7 readback"),
        reg_rdata, exp_read(reg_addr));
  endtask

  // one clock: inputs already driven after a negedge
  task automatic cyc();
    logic [1:0] nst;
    logic [5:0] nctrl;
    logic nls;
    logic [4:0] napp;
    nst = exp_next_mode(m_st, m_ctrl, id2);
    napp = (m_ctrl[0] && !m_ctrl[1]) ? {m_ctrl[5:2], m_ls} : m_app;
    nctrl = m_ctrl; nls = m_ls;
    if (reg_wr && reg_addr == 0) nctrl = reg_wdata;
    if (reg_wr && reg_addr == 1) nls = reg_wdata[0];
    @(posedge clk);
    #2;
    id2 = id1; id1 = id_pin; vb2 = vb1; vb1 = vbus_pin;
    m_st = nst; m_ctrl = nctrl; m_ls = nls; m_app = napp;
    compare_all();
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [5:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    #35;
    // R1: reset values while reset is held
    reg_addr = 0; #1;
    chk(mode == 0, "R1 mode", mode, 0);
    chk(clk_en == 0, "R1 clk_en", clk_en, 0);
    chk(reg_rdata == 6'h32, "R1 ctrl reg", reg_rdata, 6'h32);
    chk({mode_sel, id_sel, vbus_pol, pad_en, ls_force} == 5'b11000, "R1 applied",
        {mode_sel, id_sel, vbus_pol, pad_en, ls_force}, 5'b11000);
    reg_addr = 1; #1;
    chk(reg_rdata == 0, "R1 speed reg", reg_rdata, 0);
    @(negedge clk); rst_n = 1;
    idle(2);

    // R6: status tracks pins while in Reset and frozen
    reg_addr = 2; id_pin = 0; vbus_pin = 1;
    cyc();
    chk(reg_rdata[1:0] == 2'b01, "R6 one-edge latency", reg_rdata[1:0], 2'b01);
    cyc();
    chk(reg_rdata[1:0] == 2'b10, "R6 two-edge latency", reg_rdata[1:0], 2'b10);
    id_pin = 1;
    idle(3);

    // R7: config written while disabled is not applied
    wr(0, 6'b111110); wr(1, 6'd1);
    idle(2);
    chk(pad_en == 0 && ls_force == 0, "R7 not applied while disabled", {pad_en, ls_force}, 0);

    // R3: enable, frozen, ID high -> Device; config still held
    wr(0, 6'b011111);
    idle(1);
    chk(mode == 1, "R3 device entry", mode, 1);
    chk(pad_en == 0, "R7 held while frozen", pad_en, 0);

    // R7/R8: unfreeze applies
    wr(0, 6'b011101);
    idle(1);
    chk(pad_en == 1 && ls_force == 1 && clk_en == 1, "R7 applied when unfrozen",
        {pad_en, ls_force, clk_en}, 3'b111);

    // R4: ID drops -> Reset then Host
    id_pin = 0;
    idle(2);
    cyc();
    chk(mode == 0, "R4 pass through reset", mode, 0);
    cyc();
    chk(mode == 2, "R4 host after reset", mode, 2);

    // R3: software mode-select path
    wr(0, 6'b100001);
    idle(2);
    chk(mode == 1, "R3 mode-select device", mode, 1);

    // R2: disable returns to Reset
    wr(0, 6'b100000);
    cyc();
    chk(mode == 0, "R2 disable", mode, 0);

    // R9: writes to status / unused addresses ignored
    wr(2, 6'h3f); wr(3, 6'h3f);
    reg_addr = 0; cyc();
    chk(reg_rdata == 6'b100000, "R9 ctrl untouched", reg_rdata, 6'b100000);
    reg_addr = 1; cyc();
    chk(reg_rdata == 6'd1, "R9 speed untouched", reg_rdata, 1);
    reg_addr = 3; cyc();
    chk(reg_rdata == 0, "R9 addr3 reads zero", reg_rdata, 0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      reg_wr = ($urandom % 8) == 0;
      reg_addr = 2'($urandom);
      reg_wdata = 6'($urandom);
      if (reg_addr == 0) begin
        reg_wdata[0] = ($urandom % 5) != 0;
        reg_wdata[1] = ($urandom % 2) != 0;
      end
      if (($urandom % 40) == 0) id_pin = ~id_pin;
      if (($urandom % 30) == 0) vbus_pin = ~vbus_pin;
      cyc();
    end
    reg_wr = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule